// File: doc/BRIEF.md
# Single-Request Priority Interrupt Arbiter

This block sits between a set of interrupt lines and a processor core. Each source line is captured as a pending flag: rising-edge sources latch until the request they caused is acknowledged, and level sources follow their line. At most one request to the core is outstanding at any time. The request is presented as a 12-bit word that combines the 4-bit priority of the source with its 8-bit vector number. Vector number n is source n.

While a request is outstanding, newly pending sources wait. They do not preempt it. When the core acknowledges, the request is released. In the following cycle a priority search over all pending sources picks the next one to issue. A fast-interrupt register can divert one chosen vector to a separate output, so the core can take that vector through a quicker path. A byte-wide register bus holds the following:

- the enable bytes;
- the priority registers, where sources 2k and 2k+1 share register k;
- the fast-interrupt register;
- a software-interrupt trigger.

Top module: `icu_arbiter`

## Requirements
- R1: After synchronous reset, no request is outstanding, `req_word` and `fast_word` are 0, and all enable, priority and fast-interrupt registers read 0.
- R2: When no request is outstanding and source n (n ≥ 1) becomes pending, the request is issued at the next clock edge. A source becomes pending on a rising edge of its line, or on a high line if it is a level source. The source must be enabled through bit n%8 of the enable byte at address 0x00+n/8. Among simultaneous new events, the lowest-numbered source wins. The word is {priority[3:0], vector[7:0]}, and the priority comes from the register at address 0x10+n/2.
- R3: While a request is outstanding and not acknowledged or withdrawn, the request is held unchanged, even if other sources become pending, including sources of higher priority.
- R4: An `ack` while a request is outstanding makes both outputs 0 at the next edge. It also clears the pending flag of that source if the source is edge-triggered.
- R5: In the cycle after an acknowledge, the pending source with the strictly highest nonzero priority is selected. On a tie, the lowest number wins. The selected source is issued only if it is enabled and its vector is not 0. If it fails that check, nothing is issued and the other pending sources keep waiting.
- R6: Vector 0 is never issued, either by a new event or by the search.
- R7: When the outstanding request belongs to a level source and that source's line goes low, the request is dropped at the next edge and both outputs become 0.
- R8: The fast-interrupt register at address 0x20 holds an enable in bit 15 and a vector in bits 7:0. When it is enabled and its vector equals the outstanding vector, the word appears on `fast_word` and `req_word` is 0.
- R9: The fast-interrupt register needs a halfword access (`bus_size`=1). All other registers need a byte access (`bus_size`=0). A write of the wrong size is ignored. A read of the wrong size, or of an unmapped address, returns 16'hFFFF.
- R10: A priority register stores only the low 4 bits written, and it reads back that masked value.
- R11: A byte write with bit 0 set to address 0x30 gives a one-cycle pulse on `swi_pulse` at the next edge. A read of 0x30 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Source interrupt lines |
| ack | input | 1 | Core acknowledges the outstanding request |
| bus_we | input | 1 | Register write strobe |
| bus_size | input | 1 | Access size: 0 byte, 1 halfword |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from address and size) |
| req_word | output | 12 | Normal request word {priority, vector}, 0 when idle |
| fast_word | output | 12 | Fast request word {priority, vector}, 0 when idle |
| swi_pulse | output | 1 | One-cycle software interrupt pulse |

## Verification
Timing of the results:
- A source event is registered at the clock edge where the line is sampled, so its request shows on the outputs one edge after the line changes.
- An acknowledge clears the outputs at its own edge.
- The priority search result appears one edge later, so the winner is due two edges after `ack` is driven.
- Read data is combinational.

Every stimulus vector is driven at a falling edge, and the outputs are compared at the next falling edge. This puts each comparison exactly one rising edge after its stimulus. The post-acknowledge search is checked with a separate idle vector. Register reads are sampled shortly after the address is set, away from any rising edge.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int VEC_W   = 8;
    localparam int PRIO_W  = 4;
    localparam int WORD_W  = PRIO_W + VEC_W;

    localparam int EN_BASE   = 'h00;
    localparam int PRIO_BASE = 'h10;
    localparam int FAST_ADDR = 'h20;
    localparam int SWI_ADDR  = 'h30;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_HALF = 1'b1
    } acc_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } req_t;

    function automatic logic [WORD_W-1:0] mk_word(input logic [PRIO_W-1:0] p,
                                                  input logic [VEC_W-1:0] v);
        return {p, v};
    endfunction

endpackage

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_PRIO = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic                     bus_size,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    output logic [NUM_SRC-1:0]       en_bits,
    output logic [NUM_PRIO*PRIO_W-1:0] prio_flat,
    output logic                     fast_en,
    output logic [VEC_W-1:0]         fast_vec,
    output logic                     swi_pulse
);
    localparam int NUM_EN = (NUM_SRC + 7) / 8;

    logic [7:0]        en_q   [NUM_EN];
    logic [PRIO_W-1:0] prio_q [NUM_PRIO];
    logic              fen_q;
    logic [VEC_W-1:0]  fvec_q;
    logic              swi_q;

    wire is_byte = (acc_e'(bus_size) == ACC_BYTE);
    wire is_half = (acc_e'(bus_size) == ACC_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_EN; k++)   en_q[k]   <= '0;
            for (int k = 0; k < NUM_PRIO; k++) prio_q[k] <= '0;
            fen_q  <= 1'b0;
            fvec_q <= '0;
            swi_q  <= 1'b0;
        end else begin
            swi_q <= 1'b0;
            if (bus_we) begin
                if (bus_addr == ADDR_W'(FAST_ADDR)) begin
                    if (is_half) begin
                        fen_q  <= bus_wdata[15];
                        fvec_q <= bus_wdata[VEC_W-1:0];
                    end
                end else if (is_byte) begin
                    for (int k = 0; k < NUM_EN; k++)
                        if (bus_addr == ADDR_W'(EN_BASE + k)) en_q[k] <= bus_wdata[7:0];
                    for (int k = 0; k < NUM_PRIO; k++)
                        if (bus_addr == ADDR_W'(PRIO_BASE + k)) prio_q[k] <= bus_wdata[PRIO_W-1:0];
                    if (bus_addr == ADDR_W'(SWI_ADDR)) swi_q <= bus_wdata[0];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '1;
        if (bus_addr == ADDR_W'(FAST_ADDR)) begin
            if (is_half) bus_rdata = {fen_q, 7'b0, fvec_q};
        end else if (is_byte) begin
            for (int k = 0; k < NUM_EN; k++)
                if (bus_addr == ADDR_W'(EN_BASE + k)) bus_rdata = {8'h00, en_q[k]};
            for (int k = 0; k < NUM_PRIO; k++)
                if (bus_addr == ADDR_W'(PRIO_BASE + k)) bus_rdata = {12'h000, prio_q[k]};
            if (bus_addr == ADDR_W'(SWI_ADDR)) bus_rdata = 16'h0000;
        end
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_en
        assign en_bits[n] = en_q[n/8][n%8];
    end
    for (genvar k = 0; k < NUM_PRIO; k++) begin : g_prio
        assign prio_flat[k*PRIO_W +: PRIO_W] = prio_q[k];
    end

    assign fast_en   = fen_q;
    assign fast_vec  = fvec_q;
    assign swi_pulse = swi_q;

    // R11: a pulse only ever follows a qualifying byte write
    a_r11_swi_cause: assert property (@(posedge clk) disable iff (rst)
        swi_q |-> $past(bus_we && is_byte && bus_addr == ADDR_W'(SWI_ADDR) && bus_wdata[0]));

endmodule

// File: rtl/icu_pend.sv
module icu_pend
    import icu_pkg::*;
#(
    parameter int                 NUM_SRC   = 16,
    parameter logic [NUM_SRC-1:0] LEVEL_SRC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               clr_valid,
    input  logic [VEC_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] event_v,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] pend_q;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        if (LEVEL_SRC[n]) begin : g_level
            assign event_v[n] = irq_in[n];
            always_ff @(posedge clk) begin
                if (rst) pend_q[n] <= 1'b0;
                else     pend_q[n] <= irq_in[n];
            end
        end else begin : g_edge
            assign event_v[n] = irq_in[n] & ~prev_q[n];
            always_ff @(posedge clk) begin
                if (rst)
                    pend_q[n] <= 1'b0;
                else if (event_v[n])
                    pend_q[n] <= 1'b1;
                else if (clr_valid && clr_idx == VEC_W'(n))
                    pend_q[n] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= irq_in;
    end

    assign pend = pend_q;

endmodule

// File: rtl/icu_scan.sv
module icu_scan
    import icu_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    output logic                      found,
    output logic [VEC_W-1:0]          idx,
    output logic [PRIO_W-1:0]         best
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (pend[n] && src_prio[n*PRIO_W +: PRIO_W] > best) begin
                found = 1'b1;
                idx   = VEC_W'(n);
                best  = src_prio[n*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
    import icu_pkg::*;
#(
    parameter int                 NUM_SRC    = 16,
    parameter int                 PRIO_SHARE = 2,
    parameter int                 ADDR_W     = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_SRC  = 16'h0300
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               ack,
    input  logic               bus_we,
    input  logic               bus_size,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    output logic [11:0]        req_word,
    output logic [11:0]        fast_word,
    output logic               swi_pulse
);
    localparam int NUM_PRIO = (NUM_SRC + PRIO_SHARE - 1) / PRIO_SHARE;

    logic [NUM_SRC-1:0]          en_bits;
    logic [NUM_PRIO*PRIO_W-1:0]  prio_flat;
    logic [NUM_SRC*PRIO_W-1:0]   src_prio;
    logic                        fast_en;
    logic [VEC_W-1:0]            fast_vec;
    logic [NUM_SRC-1:0]          event_v, pend;
    logic                        scan_found;
    logic [VEC_W-1:0]            scan_idx;
    logic [PRIO_W-1:0]           scan_prio;

    req_t req_q;
    logic scan_q;

    icu_regs #(.NUM_SRC(NUM_SRC), .NUM_PRIO(NUM_PRIO), .ADDR_W(ADDR_W)) u_regs (
        .clk, .rst, .bus_we, .bus_size, .bus_addr, .bus_wdata, .bus_rdata,
        .en_bits, .prio_flat, .fast_en, .fast_vec, .swi_pulse
    );

    icu_pend #(.NUM_SRC(NUM_SRC), .LEVEL_SRC(LEVEL_SRC)) u_pend (
        .clk, .rst, .irq_in,
        .clr_valid(ack && req_q.valid), .clr_idx(req_q.vec),
        .event_v, .pend
    );

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
        assign src_prio[n*PRIO_W +: PRIO_W] = prio_flat[(n/PRIO_SHARE)*PRIO_W +: PRIO_W];
    end

    icu_scan #(.NUM_SRC(NUM_SRC)) u_scan (
        .pend, .src_prio, .found(scan_found), .idx(scan_idx), .best(scan_prio)
    );

    // lowest-numbered new enabled event, vector 0 excluded
    logic             ev_found;
    logic [VEC_W-1:0] ev_idx;
    always_comb begin
        ev_found = 1'b0;
        ev_idx   = '0;
        for (int n = NUM_SRC - 1; n >= 1; n--) begin
            if (event_v[n] && en_bits[n]) begin
                ev_found = 1'b1;
                ev_idx   = VEC_W'(n);
            end
        end
    end

    // per-index lookups of the current request and of the scan winner
    logic              cur_level, cur_line, scan_en;
    logic [PRIO_W-1:0] cur_prio;
    always_comb begin
        cur_level = 1'b0;
        cur_line  = 1'b0;
        cur_prio  = '0;
        scan_en   = 1'b0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (req_q.vec == VEC_W'(n)) begin
                cur_level = LEVEL_SRC[n];
                cur_line  = irq_in[n];
                cur_prio  = src_prio[n*PRIO_W +: PRIO_W];
            end
            if (scan_idx == VEC_W'(n)) scan_en = en_bits[n];
        end
    end

    wire withdraw = cur_level && !cur_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            scan_q <= 1'b0;
        end else begin
            scan_q <= 1'b0;
            if (req_q.valid) begin
                if (ack) begin
                    req_q.valid <= 1'b0;
                    scan_q      <= 1'b1;
                end else if (withdraw) begin
                    req_q.valid <= 1'b0;
                end
            end else if (scan_q && scan_found && scan_en && scan_idx != '0) begin
                req_q <= '{valid: 1'b1, vec: scan_idx};
            end else if (ev_found) begin
                req_q <= '{valid: 1'b1, vec: ev_idx};
            end
        end
    end

    wire              to_fast = fast_en && (fast_vec == req_q.vec);
    wire [WORD_W-1:0] word    = mk_word(cur_prio, req_q.vec);

    assign req_word  = (req_q.valid && !to_fast) ? word : '0;
    assign fast_word = (req_q.valid &&  to_fast) ? word : '0;

    a_r6_no_vector_zero: assert property (@(posedge clk) disable iff (rst)
        req_q.valid |-> req_q.vec != '0);

    a_r8_one_output: assert property (@(posedge clk) disable iff (rst)
        !(req_word != '0 && fast_word != '0));

    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        ack && req_q.valid |=> req_word == '0 && fast_word == '0);

    a_r7_withdraw: assert property (@(posedge clk) disable iff (rst)
        req_q.valid && !ack && withdraw |=> !req_q.valid);

    a_r3_no_preempt: assert property (@(posedge clk) disable iff (rst)
        req_q.valid && !ack && !withdraw |=> req_q.valid && $stable(req_q.vec));

    a_r5_scan_nonzero: assert property (@(posedge clk) disable iff (rst)
        scan_found |-> scan_prio != '0 && pend != '0);

endmodule

// File: tb/icu_arbiter_bench.sv
module icu_arbiter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] irq_in;
    logic        ack;
    logic        bus_we;
    logic        bus_size;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [11:0] req_word, fast_word;
    logic        swi_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icu_arbiter u_icu_arbiter (
        .clk, .rst, .irq_in, .ack, .bus_we, .bus_size, .bus_addr,
        .bus_wdata, .bus_rdata, .req_word, .fast_word, .swi_pulse
    );

    // {irq[15:0], ack, exp req_word[11:0], exp fast_word[11:0]}
    localparam int NV = 19;
    localparam logic [40:0] VECS [NV] = '{
        {16'h0004, 1'b0, 12'h302, 12'h000},  // R2 src2 issued
        {16'h00C4, 1'b0, 12'h302, 12'h000},  // R3 no preemption
        {16'h00C4, 1'b1, 12'h000, 12'h000},  // R4 ack releases
        {16'h00C4, 1'b0, 12'h706, 12'h000},  // R5 tie -> src6
        {16'h00E4, 1'b0, 12'h706, 12'h000},  // R3 hold
        {16'h00E4, 1'b1, 12'h000, 12'h000},  // R4
        {16'h00E4, 1'b0, 12'h000, 12'h000},  // R5 winner src5 disabled
        {16'h00E6, 1'b0, 12'h101, 12'h000},  // R2 src1
        {16'h00E6, 1'b1, 12'h000, 12'h000},  // R4
        {16'h00E6, 1'b0, 12'h000, 12'h000},  // R5
        {16'h10E6, 1'b0, 12'h000, 12'h90C},  // R8 fast vector 12
        {16'h10E6, 1'b1, 12'h000, 12'h000},  // R4
        {16'h10E6, 1'b0, 12'h000, 12'h000},  // R5
        {16'h11E6, 1'b0, 12'h508, 12'h000},  // R2 level src8
        {16'h10E6, 1'b0, 12'h000, 12'h000},  // R7 withdraw
        {16'h14E6, 1'b0, 12'h00A, 12'h000},  // R2 prio-0 source on event
        {16'h14E6, 1'b1, 12'h000, 12'h000},  // R4
        {16'h14E6, 1'b0, 12'h000, 12'h000},  // R5 prio 0 never scanned
        {16'h14E7, 1'b0, 12'h000, 12'h000}   // R6 vector 0 not issued
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic sz, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic sz, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        rst = 1'b1; irq_in = '0; ack = 1'b0;
        bus_we = 1'b0; bus_size = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1 req_word", {4'h0, req_word}, 16'h0000);
        check("R1 fast_word", {4'h0, fast_word}, 16'h0000);
        rd(8'h00, 1'b0, d); check("R1 enable byte", d, 16'h0000);
        rd(8'h20, 1'b1, d); check("R1 fast reg", d, 16'h0000);

        // configuration
        wr(8'h00, 1'b0, 16'h00DF);   // src5 disabled
        wr(8'h01, 1'b0, 16'h00FF);
        wr(8'h10, 1'b0, 16'h0001);
        wr(8'h11, 1'b0, 16'h0003);
        wr(8'h12, 1'b0, 16'h0007);
        wr(8'h13, 1'b0, 16'h0007);
        wr(8'h14, 1'b0, 16'h0005);
        wr(8'h15, 1'b0, 16'h0000);
        wr(8'h16, 1'b0, 16'h0029);   // R10 upper bits dropped
        wr(8'h17, 1'b0, 16'h0002);
        wr(8'h20, 1'b1, 16'h800C);

        rd(8'h16, 1'b0, d); check("R10 prio mask", d, 16'h0009);
        rd(8'h20, 1'b1, d); check("R8 fast readback", d, 16'h800C);
        rd(8'h20, 1'b0, d); check("R9 fast byte read", d, 16'hFFFF);
        rd(8'h10, 1'b1, d); check("R9 prio half read", d, 16'hFFFF);
        rd(8'h7F, 1'b0, d); check("R9 unmapped read", d, 16'hFFFF);
        wr(8'h10, 1'b1, 16'h000F);
        rd(8'h10, 1'b0, d); check("R9 wrong-size write ignored", d, 16'h0001);
        wr(8'h20, 1'b0, 16'h0000);
        rd(8'h20, 1'b1, d); check("R9 fast byte write ignored", d, 16'h800C);

        // R11 software interrupt
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h30; bus_size = 1'b0; bus_wdata = 16'h0001;
        @(negedge clk);
        bus_we = 1'b0;
        check("R11 pulse high", {15'h0, swi_pulse}, 16'h0001);
        @(negedge clk);
        check("R11 pulse one cycle", {15'h0, swi_pulse}, 16'h0000);
        rd(8'h30, 1'b0, d); check("R11 read zero", d, 16'h0000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            irq_in = VECS[i][40:25];
            ack    = VECS[i][24];
            @(negedge clk);
            ack = 1'b0;
            check($sformatf("R2-table step %0d req_word", i), {4'h0, req_word}, {4'h0, VECS[i][23:12]});
            check($sformatf("R8-table step %0d fast_word", i), {4'h0, fast_word}, {4'h0, VECS[i][11:0]});
        end

        // R5: after enabling src5, search picks it over equal-priority src7
        wr(8'h00, 1'b0, 16'h00FF);
        irq_in = 16'h54E7;           // src14 rises (prio 2)
        @(negedge clk);
        check("R2 src14 issued", {4'h0, req_word}, 16'h020E);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R4 src14 released", {4'h0, req_word}, 16'h0000);
        @(negedge clk);
        check("R5 search picks src5", {4'h0, req_word}, 16'h0705);

        finish_run();
    end
endmodule